// File: doc/BRIEF.md
# UART Automatic RTS/CTS Flow Control

This block sits between a UART's receive FIFO, its transmitter and the two modem handshake lines. It keeps a far-end sender from overrunning the local receive FIFO, and it holds back the local transmitter while the far end signals that it cannot accept data. Two bits of the modem control register select the mode: both directions automatic, clear-to-send gating only, or fully manual.

With automatic request-to-send, the RTS line is withdrawn early. The trigger is the receiver's strobe for the first data bit of the character that will take the last free FIFO slot. The line is not withdrawn only when the FIFO reports full. This gives the far end a whole character time to react. RTS comes back once reads bring the occupancy below the release level. With automatic clear-to-send, the CTS pin passes through a synchronizer and then gates a transmit-permit signal. The transmitter looks at that signal only when it is about to start a new character, so a character already on the line always finishes.

Both pins are active low. Inside the block, all logic uses active-high meaning.

Top module: `uart_afc`

## Requirements
- R1: Mode decode uses control bit 5 (auto enable) and bit 1 (RTS bit). With bit5=1 and bit1=1, auto-RTS and auto-CTS are both on. With bit5=1 and bit1=0, only auto-CTS is on. With bit5=0, no automatic flow control is on, whatever bit 1 holds.
- R2: With auto-CTS on, `tx_permit_o` is 1 exactly when the synchronized `cts_n_i` is 0. A change on the pin reaches `tx_permit_o` SYNC_STAGES+1 rising edges later.
- R3: With auto-CTS off, `tx_permit_o` is 1 whatever level `cts_n_i` has.
- R4: With auto-RTS on and occupancy below DEPTH-1, `rts_n_o` is 0 (active).
- R5: With auto-RTS on, a pulse on `rx_first_bit_i` while occupancy equals DEPTH-1 drives `rts_n_o` to 1 after the next rising edge. The same pulse at lower occupancy has no effect on `rts_n_o`.
- R6: With auto-RTS on, an occupancy of DEPTH or more drives `rts_n_o` to 1, even without a strobe.
- R7: Once released, `rts_n_o` stays 1 while occupancy is DEPTH-1 or more. It returns to 0 after the first edge at which occupancy is below DEPTH-1.
- R8: With auto-RTS off, `rts_n_o` equals the inverse of control bit 1 one edge later. While auto-RTS is off, the strobe and the occupancy have no effect on it.
- R9: While `rst` is high, `rts_n_o` is 1 and `tx_permit_o` is 0.
- R10: Control bits other than 5 and 1 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mcr_i | input | 8 | Modem control register contents (bits 5 and 1 used) |
| rx_count_i | input | CNT_W | Receive FIFO occupancy |
| rx_first_bit_i | input | 1 | One-cycle strobe: receiver sampled data bit 0 of a character |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| rts_n_o | output | 1 | Request-to-send pin, active low, registered |
| tx_permit_o | output | 1 | Transmitter may start a new character |

## Verification
The bench builds the block with DEPTH=16 and SYNC_STAGES=2, which gives a 5-bit occupancy and a release level of 15. With these values the bench can drive occupancy to exactly one below full, to full, and back down through the threshold. With a two-stage synchronizer, the three-edge CTS latency can be measured edge by edge. The vector table covers the mode decode, the early-release hysteresis and the control bits that must be ignored. Directed tests cover reset and the exact latency of each output.

// File: rtl/afc_pkg.sv
package afc_pkg;
  localparam int MCR_AUTO_BIT = 5;
  localparam int MCR_RTS_BIT  = 1;

  typedef enum logic [1:0] {
    AFC_OFF  = 2'd0,
    AFC_CTS  = 2'd1,
    AFC_BOTH = 2'd2
  } afc_mode_e;

  function automatic afc_mode_e afc_decode(input logic [7:0] mcr);
    if (!mcr[MCR_AUTO_BIT])    return AFC_OFF;
    else if (mcr[MCR_RTS_BIT]) return AFC_BOTH;
    else                       return AFC_CTS;
  endfunction
endpackage

// File: rtl/afc_cts_gate.sv
module afc_cts_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic auto_cts_i,
  input  logic cts_n_i,
  output logic tx_permit_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   cts_n_sync;
  logic                   permit_q;

  // Bring the asynchronous pin into the clock domain; idle level is inactive (high).
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], cts_n_i};
  end

  assign cts_n_sync = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst)             permit_q <= 1'b0;
    else if (auto_cts_i) permit_q <= ~cts_n_sync;
    else                 permit_q <= 1'b1;
  end

  assign tx_permit_o = permit_q;

  // R2: inactive synchronized CTS withdraws the permit
  assert_cts_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    (auto_cts_i && cts_n_sync) |=> !tx_permit_o);
  // R2: active synchronized CTS grants the permit
  assert_cts_grants_R2: assert property (@(posedge clk) disable iff (rst)
    (auto_cts_i && !cts_n_sync) |=> tx_permit_o);
  // R3: without auto-CTS the permit is always given
  assert_no_gate_R3: assert property (@(posedge clk) disable iff (rst)
    !auto_cts_i |=> tx_permit_o);
endmodule

// File: rtl/afc_rts_ctrl.sv
module afc_rts_ctrl #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_rts_i,
  input  logic             sw_rts_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             rx_first_bit_i,
  output logic             rts_n_o
);
  localparam logic [CNT_W-1:0] REL_LVL  = CNT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  logic hold_q, hold_nxt;
  logic rts_n_q;
  logic at_rel, at_full;

  assign at_rel  = (rx_count_i >= REL_LVL);
  assign at_full = (rx_count_i >= FULL_LVL);

  // Early release: the last free slot is being filled by the character now on the wire.
  always_comb begin
    if (!auto_rts_i)                           hold_nxt = 1'b0;
    else if ((rx_first_bit_i && at_rel) || at_full) hold_nxt = 1'b1;
    else if (!at_rel)                          hold_nxt = 1'b0;
    else                                       hold_nxt = hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= 1'b0;
      rts_n_q <= 1'b1;
    end else begin
      hold_q  <= hold_nxt;
      rts_n_q <= auto_rts_i ? hold_nxt : ~sw_rts_i;
    end
  end

  assign rts_n_o = rts_n_q;

  // R5: strobe at the release level drops RTS on the next edge
  assert_early_release_R5: assert property (@(posedge clk) disable iff (rst)
    (auto_rts_i && rx_first_bit_i && rx_count_i == REL_LVL) |=> rts_n_o);
  // R6: a full FIFO never leaves RTS active
  assert_full_release_R6: assert property (@(posedge clk) disable iff (rst)
    (auto_rts_i && at_full) |=> rts_n_o);
  // R4: below the release level with auto-RTS, RTS is active
  assert_below_active_R4: assert property (@(posedge clk) disable iff (rst)
    (auto_rts_i && !at_rel) |=> !rts_n_o);
  // R8: manual mode mirrors the software bit
  assert_manual_follow_R8: assert property (@(posedge clk) disable iff (rst)
    !auto_rts_i |=> (rts_n_o == !$past(sw_rts_i)));
endmodule

// File: rtl/uart_afc.sv
module uart_afc
  import afc_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       mcr_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             rx_first_bit_i,
  input  logic             cts_n_i,
  output logic             rts_n_o,
  output logic             tx_permit_o
);
  afc_mode_e mode;
  logic      auto_cts, auto_rts;

  assign mode     = afc_decode(mcr_i);
  assign auto_cts = (mode == AFC_CTS) || (mode == AFC_BOTH);
  assign auto_rts = (mode == AFC_BOTH);

  afc_cts_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk         (clk),
    .rst         (rst),
    .auto_cts_i  (auto_cts),
    .cts_n_i     (cts_n_i),
    .tx_permit_o (tx_permit_o)
  );

  afc_rts_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rts (
    .clk            (clk),
    .rst            (rst),
    .auto_rts_i     (auto_rts),
    .sw_rts_i       (mcr_i[MCR_RTS_BIT]),
    .rx_count_i     (rx_count_i),
    .rx_first_bit_i (rx_first_bit_i),
    .rts_n_o        (rts_n_o)
  );

  // R1: auto-RTS never runs without auto-CTS
  assert_mode_nest_R1: assert property (@(posedge clk) disable iff (rst)
    auto_rts |-> auto_cts);
  // R9: outputs sit at their safe values one edge into reset
  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (rts_n_o && !tx_permit_o));
endmodule

// File: tb/test_uart_afc.sv
module test_uart_afc;
  localparam int  DEPTH  = 16;
  localparam int  SYNC   = 2;
  localparam int  CNT_W  = 5;
  localparam time PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [7:0]       mcr = 8'h00;
  logic [CNT_W-1:0] cnt = '0;
  logic             stb = 1'b0;
  logic             cts_n = 1'b1;
  logic             rts_n, permit;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(PERIOD/2) clk = ~clk;

  uart_afc #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC)) i_uart_afc (
    .clk(clk), .rst(rst), .mcr_i(mcr), .rx_count_i(cnt),
    .rx_first_bit_i(stb), .cts_n_i(cts_n),
    .rts_n_o(rts_n), .tx_permit_o(permit)
  );

  // {req[20:17], mcr[16:9], cnt[8:4], stb[3], cts_n[2], exp_rts_n[1], exp_permit[0]}
  localparam int NV = 17;
  localparam logic [20:0] VEC [NV] = '{
    {4'd3,  8'h00, 5'd0,  1'b0, 1'b1, 1'b1, 1'b1}, // R3 R1 manual, sw=0
    {4'd8,  8'h02, 5'd0,  1'b0, 1'b1, 1'b0, 1'b1}, // R8 sw RTS on
    {4'd8,  8'h02, 5'd15, 1'b1, 1'b1, 1'b0, 1'b1}, // R8 strobe ignored when manual
    {4'd2,  8'h20, 5'd0,  1'b0, 1'b1, 1'b1, 1'b0}, // R2 R1 CTS-only, CTS inactive
    {4'd2,  8'h20, 5'd0,  1'b0, 1'b0, 1'b1, 1'b1}, // R2 CTS active
    {4'd4,  8'h22, 5'd3,  1'b0, 1'b0, 1'b0, 1'b1}, // R4 R1 both auto
    {4'd5,  8'h22, 5'd10, 1'b1, 1'b0, 1'b0, 1'b1}, // R5 strobe below level no effect
    {4'd4,  8'h22, 5'd15, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 level without strobe
    {4'd5,  8'h22, 5'd15, 1'b1, 1'b0, 1'b1, 1'b1}, // R5 early release
    {4'd7,  8'h22, 5'd16, 1'b0, 1'b0, 1'b1, 1'b1}, // R7 filled
    {4'd7,  8'h22, 5'd15, 1'b0, 1'b0, 1'b1, 1'b1}, // R7 still at level
    {4'd7,  8'h22, 5'd14, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 re-assert
    {4'd6,  8'h22, 5'd16, 1'b0, 1'b0, 1'b1, 1'b1}, // R6 full without strobe
    {4'd7,  8'h22, 5'd2,  1'b0, 1'b1, 1'b0, 1'b0}, // R7 R2 drained, CTS inactive
    {4'd10, 8'hFF, 5'd2,  1'b0, 1'b0, 1'b0, 1'b1}, // R10 extra bits set, both auto
    {4'd10, 8'hDD, 5'd2,  1'b0, 1'b1, 1'b1, 1'b1}, // R10 bit5=0 bit1=0 others set
    {4'd8,  8'h02, 5'd16, 1'b0, 1'b1, 1'b0, 1'b1}  // R8 manual overrides full
  };

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 50000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // Reset state (R9)
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", rts_n, 1'b1, "rts_n in reset");
    check("R9", permit, 1'b0, "permit in reset");
    rst = 1'b0;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mcr = VEC[i][16:9]; cnt = VEC[i][8:4]; stb = VEC[i][3]; cts_n = VEC[i][2];
      @(posedge clk);
      @(negedge clk);
      stb = 1'b0;
      repeat (SYNC + 1) @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VEC[i][20:17], i), rts_n, VEC[i][1], "rts_n");
      check($sformatf("R%0d vec%0d", VEC[i][20:17], i), permit, VEC[i][0], "permit");
    end

    // R2 exact latency: CTS low reaches permit on the third edge
    @(negedge clk);
    mcr = 8'h22; cnt = 5'd0; cts_n = 1'b1;
    repeat (SYNC + 2) @(posedge clk);
    @(negedge clk);
    cts_n = 1'b0;
    repeat (SYNC) @(posedge clk);
    @(negedge clk);
    check("R2", permit, 1'b0, "permit before sync delay");
    @(posedge clk);
    @(negedge clk);
    check("R2", permit, 1'b1, "permit after sync delay");

    // R5 exact latency: one edge from strobe to release
    cnt = 5'd15;
    @(posedge clk);
    @(negedge clk);
    check("R5", rts_n, 1'b0, "rts_n at level before strobe");
    stb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stb = 1'b0;
    check("R5", rts_n, 1'b1, "rts_n one edge after strobe");
    // R7: held while at level, released one edge after dropping below
    cnt = 5'd14;
    @(posedge clk);
    @(negedge clk);
    check("R7", rts_n, 1'b0, "rts_n one edge after drain");

    // R9: reset mid-run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9", rts_n, 1'b1, "rts_n after reset");
    check("R9", permit, 1'b0, "permit after reset");

    finish_run();
  end
endmodule